// File: doc/BRIEF.md
# Hamming (7,4) Parity Generator and Error Locator Panel

This block turns a bank of eight switches into a small Hamming (7,4) workbench. Seven switches hold a codeword, and the eighth chooses the operating mode. In generate mode the block reads the four data positions and lights three LEDs with the parity bits that belong with them. In check mode it recomputes all three checks over the full seven-bit word. The LEDs then show the resulting syndrome, and a seven-segment digit shows the position of a single flipped bit, with 0 meaning the word is clean.

The coding path is purely combinational. A small scan state machine drives a four-digit, common-anode style display whose segment and digit-enable lines are all active low. Only the rightmost digit is ever lit. The scan divides the system clock so that this digit is refreshed once per frame at `REFRESH_HZ`, which is about 1 kHz from a 50 MHz clock. The scan machine has four states: `SLOT_LIVE`, where the rightmost digit is enabled, and `SLOT_IDLE1`, `SLOT_IDLE2` and `SLOT_IDLE3`, where every digit is dark. Each slot lasts `CLK_HZ/(REFRESH_HZ*4)` cycles. On each slot tick the machine takes the transitions `SLOT_LIVE`→`SLOT_IDLE1`→`SLOT_IDLE2`→`SLOT_IDLE3`→`SLOT_LIVE`. Reset returns it to `SLOT_LIVE`.

Top module: `ham74_panel`

## Requirements
- R1: Codeword position k (1..7) is read from switch `sw[8-k]`. Positions 1, 2 and 4 carry parity, and positions 3, 5, 6 and 7 carry data.
- R2: `sw[0]` high selects generate mode and `sw[0]` low selects check mode.
- R3: In generate mode, `led[0]` is p1 = pos3^pos5^pos7, `led[1]` is p2 = pos3^pos6^pos7, and `led[2]` is p4 = pos5^pos6^pos7.
- R4: In generate mode, the switches at positions 1, 2 and 4 have no effect on `led`.
- R5: In check mode, `led` is the syndrome {c4,c2,c1}. Each check is the XOR of its parity position and the data positions it covers, so a valid codeword gives 0.
- R6: In check mode, a valid codeword with exactly one bit flipped at position k gives a syndrome equal to k.
- R7: In check mode, `seg_n[6:0]` shows the syndrome as a decimal digit. The bit order is {g,f,e,d,c,b,a} and the lines are active low. The lit-segment patterns for digits 0..7 are 3F, 06, 5B, 4F, 66, 6D, 7D and 07 (hex, active high before inversion).
- R8: In generate mode, `seg_n` is all ones, so the display is blank.
- R9: `an_n[3:1]` is always high, and `an_n[0]` is the only enable that is ever driven low.
- R10: The scan machine cycles through four slots of `CLK_HZ/(REFRESH_HZ*4)` cycles each. `an_n[0]` is low only during the first slot.
- R11: While `rst_n` is low, the scan machine is held in the first slot with its cycle counter at zero, so `an_n[0]` is low and the slot timing restarts from zero when `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw | input | 8 | sw[7:1] codeword positions 1..7, sw[0] mode select |
| led | output | 3 | Parity bits (generate) or syndrome (check) |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| an_n | output | 4 | Active-low digit enables, bit 0 rightmost |

## Verification
The hardest behaviour to reach from the ports is the complete set of single-bit faults. Every one of the seven positions must be corrupted on top of every valid codeword, and none of these words can be entered without first computing correct parity. The stimulus builds all 16 clean codewords from expected parity bits worked out independently. It then flips each position in turn, which covers all 112 single faults and every syndrome digit. The scan slot timing is observed by sampling the digit enable on every cycle for two full frames right after reset is released.

// File: rtl/ham74_pkg.sv
package ham74_pkg;
    localparam int CW_BITS  = 7;
    localparam int PAR_BITS = 3;
    localparam int SEG_BITS = 7;
    localparam int DIGITS   = 4;
    localparam int SW_BITS  = CW_BITS + 1;

    typedef logic [CW_BITS-1:0]  cw_t;   // cw[k-1] holds position k
    typedef logic [PAR_BITS-1:0] syn_t;
    typedef logic [SEG_BITS-1:0] seg_t;

    typedef enum logic [1:0] {
        SLOT_LIVE  = 2'd0,
        SLOT_IDLE1 = 2'd1,
        SLOT_IDLE2 = 2'd2,
        SLOT_IDLE3 = 2'd3
    } scan_state_e;
endpackage

// File: rtl/ham74_code_core.sv
module ham74_code_core
    import ham74_pkg::*;
(
    input  cw_t  cw,
    input  logic gen_mode,
    output syn_t led_val,
    output syn_t syndrome
);
    syn_t parity;

    // Check j covers every position whose index has bit j set.
    for (genvar j = 0; j < PAR_BITS; j++) begin : g_check
        always_comb begin
            parity[j]   = 1'b0;
            syndrome[j] = 1'b0;
            for (int p = 1; p <= CW_BITS; p++) begin
                if (((p >> j) & 1) == 1) begin
                    syndrome[j] = syndrome[j] ^ cw[p-1];
                    if ((p & (p - 1)) != 0) begin
                        parity[j] = parity[j] ^ cw[p-1];
                    end
                end
            end
        end
    end

    assign led_val = gen_mode ? parity : syndrome;
endmodule

// File: rtl/ham74_seg_decode.sv
module ham74_seg_decode
    import ham74_pkg::*;
(
    input  syn_t digit,
    input  logic blank,
    output seg_t seg_n
);
    seg_t lit;

    always_comb begin
        unique case (digit)
            3'd0: lit = 7'h3F;
            3'd1: lit = 7'h06;
            3'd2: lit = 7'h5B;
            3'd3: lit = 7'h4F;
            3'd4: lit = 7'h66;
            3'd5: lit = 7'h6D;
            3'd6: lit = 7'h7D;
            3'd7: lit = 7'h07;
            default: lit = '0;
        endcase
    end

    assign seg_n = blank ? '1 : ~lit;
endmodule

// File: rtl/ham74_scan_fsm.sv
module ham74_scan_fsm
    import ham74_pkg::*;
#(
    parameter int SLOT_CYCLES = 12500
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DIGITS-1:0] an_n
);
    localparam int SLOTS = (SLOT_CYCLES < 1) ? 1 : SLOT_CYCLES;
    localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOTS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    scan_state_e      state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_LIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                SLOT_LIVE:  state_d = SLOT_IDLE1;
                SLOT_IDLE1: state_d = SLOT_IDLE2;
                SLOT_IDLE2: state_d = SLOT_IDLE3;
                SLOT_IDLE3: state_d = SLOT_LIVE;
                default:    state_d = SLOT_LIVE;
            endcase
        end
    end

    always_comb begin
        an_n = '1;
        unique case (state_q)
            SLOT_LIVE:  an_n[0] = 1'b0;
            SLOT_IDLE1: an_n[0] = 1'b1;
            SLOT_IDLE2: an_n[0] = 1'b1;
            SLOT_IDLE3: an_n[0] = 1'b1;
            default:    an_n[0] = 1'b1;
        endcase
    end
endmodule

// File: rtl/ham74_panel.sv
module ham74_panel
    import ham74_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int REFRESH_HZ = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SW_BITS-1:0] sw,
    output logic [PAR_BITS-1:0] led,
    output logic [SEG_BITS-1:0] seg_n,
    output logic [DIGITS-1:0]   an_n
);
    localparam int SLOT_CYCLES = CLK_HZ / (REFRESH_HZ * DIGITS);

    cw_t  cw;
    syn_t syndrome;
    logic gen_mode;

    for (genvar k = 1; k <= CW_BITS; k++) begin : g_map
        assign cw[k-1] = sw[SW_BITS-k];
    end

    assign gen_mode = sw[0];

    ham74_code_core code_i (
        .cw       (cw),
        .gen_mode (gen_mode),
        .led_val  (led),
        .syndrome (syndrome)
    );

    ham74_seg_decode seg_i (
        .digit (syndrome),
        .blank (gen_mode),
        .seg_n (seg_n)
    );

    ham74_scan_fsm #(
        .SLOT_CYCLES (SLOT_CYCLES)
    ) scan_i (
        .clk   (clk),
        .rst_n (rst_n),
        .an_n  (an_n)
    );
endmodule

// File: rtl/ham74_panel_chk.sv
module ham74_panel_chk
    import ham74_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [SW_BITS-1:0]  sw,
    input logic [PAR_BITS-1:0] led,
    input logic [SEG_BITS-1:0] seg_n,
    input logic [DIGITS-1:0]   an_n
);
    // R4: in generate mode, changing only parity-position switches leaves the LEDs unchanged
    a_r4_parity_switch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sw[0] && $past(sw[0]) && sw[5] == $past(sw[5]) && sw[3:1] == $past(sw[3:1]))
        |-> $stable(led));

    // R8: the display is blank in generate mode
    a_r8_blank_in_generate: assert property (@(posedge clk) disable iff (!rst_n)
        sw[0] |-> (seg_n == '1));

    // R7: a zero syndrome in check mode shows the digit 0
    a_r7_clean_shows_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw[0] && led == '0) |-> (seg_n == 7'b1000000));

    // R9: only the rightmost enable may go low
    a_r9_single_anode: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (an_n[DIGITS-1:1] == '1));

    // R10: after the live slot ends, the next cycle is still dark
    a_r10_idle_follows_live: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(an_n[0]) |=> an_n[0]);
endmodule

bind ham74_panel ham74_panel_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .sw    (sw),
    .led   (led),
    .seg_n (seg_n),
    .an_n  (an_n)
);

// File: tb/ham74_panel_tb.sv
module ham74_panel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sw = 8'h00;
    logic [2:0] led;
    logic [6:0] seg_n;
    logic [3:0] an_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    ham74_panel #(.CLK_HZ(16000), .REFRESH_HZ(1000)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw(sw), .led(led), .seg_n(seg_n), .an_n(an_n)
    );

    function automatic logic [6:0] digit_pat(input int d);
        case (d)
            0: digit_pat = 7'h3F;
            1: digit_pat = 7'h06;
            2: digit_pat = 7'h5B;
            3: digit_pat = 7'h4F;
            4: digit_pat = 7'h66;
            5: digit_pat = 7'h6D;
            6: digit_pat = 7'h7D;
            default: digit_pat = 7'h07;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Switch word with data at positions 3,5,6,7 and given parity bits at 1,2,4.
    function automatic logic [7:0] make_sw(input logic [3:0] d, input logic [2:0] p, input logic mode);
        logic [7:0] s;
        s = 8'h00;
        s[8-3] = d[0];
        s[8-5] = d[1];
        s[8-6] = d[2];
        s[8-7] = d[3];
        s[8-1] = p[0];
        s[8-2] = p[1];
        s[8-4] = p[2];
        s[0] = mode;
        return s;
    endfunction

    function automatic logic [2:0] exp_par(input logic [3:0] d);
        logic p1, p2, p4;
        p1 = d[0] ^ d[1] ^ d[3];
        p2 = d[0] ^ d[2] ^ d[3];
        p4 = d[1] ^ d[2] ^ d[3];
        return {p4, p2, p1};
    endfunction

    task automatic apply(input logic [7:0] s);
        @(negedge clk);
        sw = s;
        #1;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        sw = 8'h01;
        repeat (2) @(negedge clk);
        check("R11 live slot held in reset", {31'd0, an_n[0]}, 32'd0);
        check("R9 upper enables high in reset", {29'd0, an_n[3:1]}, 32'h7);
        check("R8 blank after reset in generate mode", {25'd0, seg_n}, 32'h7F);
    endtask

    task automatic t_scan_timing();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < 32; j++) begin
            if (j > 0) @(negedge clk);
            check("R10 scan slot enable", {31'd0, an_n[0]}, ((j / 4) % 4 == 0) ? 32'd0 : 32'd1);
            check("R9 upper enables high", {29'd0, an_n[3:1]}, 32'h7);
        end
    endtask

    task automatic t_generate_all();
        for (int w = 0; w < 16; w++) begin
            apply(make_sw(w[3:0], 3'b000, 1'b1));
            check("R3 R1 R2 parity on LEDs", {29'd0, led}, {29'd0, exp_par(w[3:0])});
            check("R8 blank in generate", {25'd0, seg_n}, 32'h7F);
            apply(make_sw(w[3:0], 3'b101, 1'b1));
            check("R4 parity switches ignored", {29'd0, led}, {29'd0, exp_par(w[3:0])});
            apply(make_sw(w[3:0], 3'b010, 1'b1));
            check("R4 parity switches ignored", {29'd0, led}, {29'd0, exp_par(w[3:0])});
        end
    endtask

    task automatic t_check_all();
        for (int w = 0; w < 16; w++) begin
            logic [7:0] good;
            good = make_sw(w[3:0], exp_par(w[3:0]), 1'b0);
            apply(good);
            check("R5 clean syndrome zero", {29'd0, led}, 32'd0);
            check("R7 digit 0 shown", {25'd0, seg_n}, {25'd0, ~digit_pat(0)});
            for (int k = 1; k <= 7; k++) begin
                logic [7:0] bad;
                bad = good;
                bad[8-k] = ~bad[8-k];
                apply(bad);
                check("R6 single flip syndrome", {29'd0, led}, k);
                check("R7 error digit shown", {25'd0, seg_n}, {25'd0, ~digit_pat(k)});
            end
        end
    endtask

    initial begin
        t_reset_state();
        t_scan_timing();
        t_generate_all();
        t_check_all();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule